// File: doc/BRIEF.md
# Delayed-Match Safety Output Rewriter

This block produces the safety output of a design whose large memories have been replaced by a few tracked slots. Each tracked slot comes as a pair. The pair has a selector value that names the slot and a monitored node that carries the address in use. Each pair also has a fixed delay, set at build time. A pair's condition holds when the selector equaled the monitored node exactly that many cycles earlier. The condition also needs enough cycles to have elapsed since reset for that look-back to exist.

The rewritten output demands the original safety signal only when every pair's condition holds. Otherwise the output is true. A failure is therefore reported only on traces where each tracked slot really was the one read at the moment that mattered. With a single pair of delay zero, the output is "selector equals read address implies original safe".

Cycle indices count from 0, starting at the first clock edge after reset is released. The output is registered, so the value seen after edge k reflects the inputs sampled at cycle k.

Top module: `dms_safe_rewriter`

## Requirements
- R1: While reset is high, and on the first edge after reset is sampled high, safe_o is 1.
- R2: safe_o is never unknown outside reset, and it updates one clock edge after the inputs it depends on are sampled.
- R3: Pair i matches in a cycle when all W bits of its selector slice sel_i[i*W +: W] equal its node slice nd_i[i*W +: W]; a difference in any single bit is a mismatch.
- R4: The condition of pair i at cycle c uses the match result of cycle c minus DLY[i], not a newer or older one.
- R5: The condition of pair i is false at every cycle c < DLY[i], so safe_o is 1 for those cycles whatever the inputs are.
- R6: The guard is the AND of all pair conditions; if any one pair's condition is false, safe_o is 1.
- R7: safe_o equals (NOT guard) OR safedef_i; when safedef_i is 1, safe_o is 1.
- R8: A pair with DLY[i] = 0 compares in the same cycle, and its condition holds from cycle 0 onward.
- R9: Correct results continue past the point where the cycle counter saturates at MAXDLY, however long the run.
- R10: A reset in the middle of a run discards all earlier match history, and the warm-up of R5 starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | NPAIRS*W | Selector values, pair i in bits [i*W +: W] |
| nd_i | input | NPAIRS*W | Monitored node values, pair i in bits [i*W +: W] |
| safedef_i | input | 1 | Original safety signal |
| safe_o | output | 1 | Rewritten safety signal, registered |

## Verification
Every result is due exactly one edge after the cycle whose inputs produce it. The pair with delay d contributes the match sampled d cycles before that cycle. The driver applies inputs on the falling edge and computes the expected output from its own match history and cycle index. It queues that value. The monitor pops the queue one time unit after the next rising edge, so each comparison lands on the edge the register updates. The warm-up window, single-bit mismatches, the reset restart and runs far past counter saturation are each driven as separate stretches.

// File: rtl/dms_pkg.sv
package dms_pkg;
  // Width that holds the values 0..m inclusive (at least 1 bit).
  function automatic int unsigned age_width(input int unsigned m);
    return (m < 1) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/dms_age_ctr.sv
module dms_age_ctr #(
  parameter int unsigned MAXC = 4,
  localparam int unsigned AGW = dms_pkg::age_width(MAXC)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [AGW-1:0] age
);
  localparam logic [AGW-1:0] LIMIT = AGW'(MAXC);

  // Cycles since reset release, saturating at MAXC.
  always_ff @(posedge clk) begin
    if (rst)
      age <= '0;
    else if (age != LIMIT)
      age <= age + 1'b1;
  end
endmodule

// File: rtl/dms_match_lane.sv
module dms_match_lane #(
  parameter int unsigned W     = 8,
  parameter int unsigned D     = 0,
  parameter int unsigned MAXC  = 4,
  localparam int unsigned AGW  = dms_pkg::age_width(MAXC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   sel,
  input  logic [W-1:0]   nd,
  input  logic [AGW-1:0] age,
  output logic           cond
);
  logic match_now;
  assign match_now = (sel == nd);

  generate
    if (D == 0) begin : g_direct
      logic lane_unused;
      assign lane_unused = ^{clk, rst, age};
      assign cond = match_now;
    end else begin : g_delay
      logic [D-1:0] hist;
      // hist[k] holds the match result from k+1 cycles ago.
      always_ff @(posedge clk) begin
        if (rst) begin
          hist <= '0;
        end else begin
          hist[0] <= match_now;
          for (int k = 1; k < int'(D); k++)
            hist[k] <= hist[k-1];
        end
      end
      assign cond = hist[D-1] && (age >= AGW'(D));
    end
  endgenerate
endmodule

// File: rtl/dms_safe_reg.sv
module dms_safe_reg #(
  parameter int unsigned NPAIRS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPAIRS-1:0] cond,
  input  logic              safedef,
  output logic              safe_q
);
  logic guard;
  assign guard = &cond;

  always_ff @(posedge clk) begin
    if (rst)
      safe_q <= 1'b1;
    else
      safe_q <= ~guard | safedef;
  end
endmodule

// File: rtl/dms_safe_rewriter.sv
module dms_safe_rewriter #(
  parameter int unsigned NPAIRS      = 3,
  parameter int unsigned W           = 8,
  parameter int unsigned MAXDLY      = 4,
  parameter int unsigned DLY [NPAIRS] = '{0, 1, 4},
  localparam int unsigned AGW        = dms_pkg::age_width(MAXDLY)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPAIRS*W-1:0] sel_i,
  input  logic [NPAIRS*W-1:0] nd_i,
  input  logic                safedef_i,
  output logic                safe_o
);
  logic [AGW-1:0]    age;
  logic [NPAIRS-1:0] cond;

  dms_age_ctr #(.MAXC(MAXDLY)) u_age (
    .clk (clk),
    .rst (rst),
    .age (age)
  );

  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    dms_match_lane #(.W(W), .D(DLY[i]), .MAXC(MAXDLY)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .sel  (sel_i[i*W +: W]),
      .nd   (nd_i[i*W +: W]),
      .age  (age),
      .cond (cond[i])
    );
  end

  dms_safe_reg #(.NPAIRS(NPAIRS)) u_out (
    .clk     (clk),
    .rst     (rst),
    .cond    (cond),
    .safedef (safedef_i),
    .safe_q  (safe_o)
  );
endmodule

// File: rtl/dms_safe_rewriter_chk.sv
module dms_safe_rewriter_chk #(
  parameter int unsigned NPAIRS      = 3,
  parameter int unsigned W           = 8,
  parameter int unsigned MAXDLY      = 4,
  parameter int unsigned DLY [NPAIRS] = '{0, 1, 4}
) (
  input logic                clk,
  input logic                rst,
  input logic [NPAIRS*W-1:0] sel_i,
  input logic [NPAIRS*W-1:0] nd_i,
  input logic                safedef_i,
  input logic                safe_o
);
  function automatic int unsigned largest();
    int unsigned m = 0;
    for (int i = 0; i < int'(NPAIRS); i++)
      if (DLY[i] > m) m = DLY[i];
    return m;
  endfunction
  localparam int unsigned TOPD = largest();

  int unsigned cyc;
  always_ff @(posedge clk) begin
    if (rst)
      cyc <= 0;
    else if (cyc < TOPD)
      cyc <= cyc + 1;
  end

  // R1
  p_reset_hold_r1: assert property (@(posedge clk) rst |=> safe_o);

  // R2
  p_known_r2: assert property (@(posedge clk) disable iff (rst) !$isunknown(safe_o));

  // R7
  p_safedef_pass_r7: assert property (@(posedge clk) disable iff (rst) safedef_i |=> safe_o);

  // R5
  p_warmup_r5: assert property (@(posedge clk) disable iff (rst) (cyc < TOPD) |=> safe_o);

  // R8 / R6: a zero-delay pair that mismatches now forces safe next edge
  for (genvar i = 0; i < NPAIRS; i++) begin : g_zero
    if (DLY[i] == 0) begin : g_on
      p_zero_mismatch_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_i[i*W +: W] != nd_i[i*W +: W]) |=> safe_o);
    end
  end
endmodule

bind dms_safe_rewriter dms_safe_rewriter_chk #(
  .NPAIRS(NPAIRS), .W(W), .MAXDLY(MAXDLY), .DLY(DLY)
) u_chk (
  .clk(clk), .rst(rst), .sel_i(sel_i), .nd_i(nd_i),
  .safedef_i(safedef_i), .safe_o(safe_o)
);

// File: tb/test_dms_safe_rewriter.sv
`timescale 1ns/1ps
module test_dms_safe_rewriter;
  localparam int NP = 3;
  localparam int W  = 8;
  localparam int BD [NP] = '{0, 1, 4};

  typedef struct {
    bit    exp;
    string req;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP*W-1:0] sel_i = '0;
  logic [NP*W-1:0] nd_i = '0;
  logic            safedef_i = 1'b1;
  logic            safe_o;

  int    n_tests = 0;
  int    n_fail = 0;
  item_t sb[$];
  bit    mh [NP][64];
  int    cidx = 0;
  bit    done = 0;

  always #2.5 clk = ~clk;

  dms_safe_rewriter i_dms_safe_rewriter (
    .clk(clk), .rst(rst), .sel_i(sel_i), .nd_i(nd_i),
    .safedef_i(safedef_i), .safe_o(safe_o)
  );

  // Monitor: one edge of latency, sampled just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_tests++;
        if (safe_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s: safe_o actual=%b expected=%b", it.req, safe_o, it.exp);
        end
      end
    end
  end

  task automatic do_reset(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rst = 1'b1;
      sb.push_back('{1'b1, "R1"});
    end
    cidx = 0;
  endtask

  // Driver: apply one cycle of inputs and queue the expected output.
  task automatic step(input logic [NP*W-1:0] s, input logic [NP*W-1:0] n,
                      input bit sd, input string tag);
    bit guard;
    @(negedge clk);
    rst = 1'b0;
    sel_i = s;
    nd_i = n;
    safedef_i = sd;
    guard = 1;
    for (int p = 0; p < NP; p++) begin
      bit ok;
      mh[p][cidx % 64] = (s[p*W +: W] == n[p*W +: W]);
      ok = (cidx >= BD[p]) && mh[p][(cidx - BD[p]) % 64];
      guard = guard & ok;
    end
    sb.push_back('{(!guard) || sd, tag});
    cidx++;
  endtask

  localparam logic [NP*W-1:0] VA = 24'hA5_3C_71;

  initial begin
    do_reset(3);                                  // R1
    // R5: all pairs match, safedef low; safe forced 1 during warm-up
    for (int k = 0; k < 4; k++) step(VA, VA, 0, "R5");
    // R7: guard now true, safe follows safedef
    for (int k = 0; k < 3; k++) step(VA, VA, 0, "R7");
    step(VA, VA, 1, "R7");
    step(VA, VA, 0, "R7");
    // R3 / R8: single-bit difference on the zero-delay pair
    step(VA, VA ^ 24'h00_00_80, 0, "R3");
    step(VA, VA ^ 24'h00_00_01, 0, "R8");
    step(VA, VA, 0, "R8");
    // R4: mismatch on delay-1 pair shows up one cycle later
    step(VA, VA ^ 24'h00_02_00, 0, "R4");
    step(VA, VA, 0, "R4");
    step(VA, VA, 0, "R4");
    // R4 / R6: mismatch on delay-4 pair affects exactly cycle +4
    step(VA, VA ^ 24'h10_00_00, 0, "R6");
    for (int k = 0; k < 6; k++) step(VA, VA, 0, "R4");
    // R10: reset mid-run restarts warm-up
    do_reset(1);
    for (int k = 0; k < 7; k++) step(VA, VA, 0, "R10");
    // R9: long run far beyond saturation
    for (int k = 0; k < 150; k++) step(VA, VA, 0, "R9");
    step(VA, VA ^ 24'h01_00_00, 0, "R9");
    for (int k = 0; k < 6; k++) step(VA, VA, 0, "R9");
    // R6 / R2: random streams with frequent matches
    for (int k = 0; k < 2000; k++) begin
      logic [NP*W-1:0] s, n;
      s = NP*W'($urandom);
      n = s;
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 5) == 0) n[p*W +: W] = n[p*W +: W] ^ W'(1 << $urandom_range(0, W-1));
      step(s, n, ($urandom_range(0, 7) == 0), "R6");
      if ($urandom_range(0, 300) == 0) do_reset(1);
    end
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule